// File: doc/BRIEF.md
# Registered-Backpressure Skid Pipeline Stage

This block is one register stage of a data pipeline that carries a word from a producer to a consumer. It uses strobe/busy flow control in both directions. The producer raises a strobe when it offers a word, and the stage returns a busy flag. Toward the consumer, the stage raises its own strobe and receives a busy flag back. The busy flag sent to the producer comes from a flip-flop, so the producer only sees a stall one clock after it happens. The stage therefore has a spare register that catches the one word already on its way. When the consumer frees up, the stage sends that spare word before it takes any new input.

The top module is a chain of `STAGES` copies of the stage, connected back to back. It defaults to two stages and a 32-bit data path. Words pass through unchanged. When nothing stalls, one word moves on every clock. Each stage adds one clock of latency.

Top module: `skid_chain`

## Requirements
- R1: The chain takes a word from the producer at a clock edge exactly when `src_stb` is 1 and `src_busy` is 0 before that edge. It never takes a word while `src_busy` is 1, so the producer must hold its word and strobe until then.
- R2: The chain delivers a word to the consumer at a clock edge exactly when `snk_stb` is 1 and `snk_busy` is 0 before that edge.
- R3: If a stage's output is valid and stalled, and it takes a word from upstream, it stores that word in its spare register. It raises its upstream busy after that same edge.
- R4: While `snk_stb` is 1 and `snk_busy` is 1, `snk_data` and `snk_stb` do not change at the next edge.
- R5: After a stall, the word in the spare register is delivered before any word that arrives later.
- R6: With `src_stb` held at 1 and `snk_busy` held at 0, a new word reaches `snk_data` on every clock and `snk_stb` stays 1.
- R7: After `snk_busy` falls, `snk_stb` stays 1 until every stored word has been delivered. It falls at the first edge after that if no new word has been taken.
- R8: A word taken at an edge reaches the output of stage k (1-based) k edges later when there are no stalls. With two stages, it shows on `snk_stb`/`snk_data` two edges after it is offered.
- R9: A clock edge with `rst_n` at 0 clears every stage. After that edge, `snk_stb` is 0 and `src_busy` is 0.
- R10: Under any pattern of strobe and busy, words leave in the order they entered. None is lost and none is duplicated.
- R11: `src_busy` is a register output. Changing `snk_busy` between clock edges does not change `src_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_stb | input | 1 | Producer offers a word |
| src_busy | output | 1 | Chain cannot take a word this cycle |
| src_data | input | WIDTH | Word from the producer |
| snk_stb | output | 1 | Chain offers a word to the consumer |
| snk_busy | input | 1 | Consumer cannot take a word this cycle |
| snk_data | output | WIDTH | Word to the consumer |

## Verification
Every output is a register, so each effect of a stimulus is sampled 2 ns after the edge it depends on. A stall shows on `src_busy` after the edge that captures the spare word (stage 2 fills first, stage 1 one edge later). A word appears on `snk_data` two edges after it is offered when nothing stalls (R8). The vector table gives the expected value after each edge, worked out one register at a time through both stages. The random test compares delivered words to a queue, and transfers are judged from signal values settled before each edge. The R11 check changes `snk_busy` in the middle of a cycle and reads `src_busy` before the next edge.

// File: rtl/skid_pkg.sv
// Shared definitions for the skid pipeline stage.
// Assumes: nothing beyond a standard SystemVerilog package scope.
package skid_pkg;

    localparam int unsigned DEFAULT_WIDTH  = 32;
    localparam int unsigned DEFAULT_STAGES = 2;

    // Source that loads the output register of a stage on the next edge
    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,   // keep the current output word
        SRC_INPUT = 2'd1,   // load the word arriving from upstream
        SRC_SPARE = 2'd2    // load the word held in the spare register
    } out_src_e;

    // A transfer happens when a strobe is offered and the receiver is not busy
    function automatic logic xfer(input logic stb, input logic busy);
        return stb & ~busy;
    endfunction

endpackage

// File: rtl/skid_ctrl.sv
// Flow-control state of one skid stage: output-valid and spare-full flags.
// Assumes: upstream holds its word while up_busy is high; the busy output
// comes only from the spare-full flop, so it has no combinational input.
module skid_ctrl
    import skid_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     up_stb,
    output logic     up_busy,
    output logic     dn_stb,
    input  logic     dn_busy,
    output out_src_e out_sel,
    output logic     spare_load
);

    logic vld_q;
    logic full_q;
    logic up_take;
    logic out_free;

    assign up_busy  = full_q;
    assign dn_stb   = vld_q;
    assign up_take  = xfer(up_stb, full_q);
    assign out_free = ~vld_q | ~dn_busy;

    // Pick the output register source and decide whether the spare captures
    always_comb begin
        out_sel    = SRC_HOLD;
        spare_load = 1'b0;
        if (out_free) begin
            if (full_q) begin
                out_sel = SRC_SPARE;
            end else if (up_take) begin
                out_sel = SRC_INPUT;
            end
        end else if (up_take) begin
            spare_load = 1'b1;
        end
    end

    // Update the valid and spare-full flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            full_q <= 1'b0;
        end else if (out_free) begin
            vld_q  <= full_q | up_take;
            full_q <= 1'b0;
        end else if (up_take) begin
            full_q <= 1'b1;
        end
    end

    // R3: a filled spare always sits behind a valid output word
    p_full_has_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        up_busy |-> dn_stb);

    // R3: a word taken while the output is stalled raises busy on the next edge
    p_capture_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_stb && dn_busy && up_stb && !up_busy) |=> up_busy);

    // R7: once downstream frees up, the spare drains and the output stays valid
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_busy && !dn_busy) |=> (!up_busy && dn_stb));

    // R7: output strobe drops once the last stored word has left
    p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_stb && !dn_busy && !up_busy && !up_stb) |=> !dn_stb);

endmodule

// File: rtl/skid_data.sv
// Data registers of one skid stage: the output word and the spare word.
// Assumes: out_sel and spare_load come from skid_ctrl; no data transform.
module skid_data
    import skid_pkg::*;
#(
    parameter int unsigned WIDTH = DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] up_data,
    input  out_src_e         out_sel,
    input  logic             spare_load,
    output logic [WIDTH-1:0] dn_data
);

    logic [WIDTH-1:0] out_q;
    logic [WIDTH-1:0] spare_q;

    assign dn_data = out_q;

    // Load the output word from the selected source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            unique case (out_sel)
                SRC_INPUT: out_q <= up_data;
                SRC_SPARE: out_q <= spare_q;
                default:   out_q <= out_q;
            endcase
        end
    end

    // Capture the in-flight word when the output is stalled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spare_q <= '0;
        end else if (spare_load) begin
            spare_q <= up_data;
        end
    end

    // R5: when the spare is chosen, the output takes exactly the spare word
    p_spare_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == SRC_SPARE) |=> (dn_data == $past(spare_q)));

endmodule

// File: rtl/skid_stage.sv
// One skid pipeline stage: flow-control flags plus output and spare words.
// Assumes: strobe/busy handshake on both sides; up_busy is registered.
module skid_stage
    import skid_pkg::*;
#(
    parameter int unsigned WIDTH = DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_stb,
    output logic             up_busy,
    input  logic [WIDTH-1:0] up_data,
    output logic             dn_stb,
    input  logic             dn_busy,
    output logic [WIDTH-1:0] dn_data
);

    out_src_e sel;
    logic     spare_load;

    skid_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_stb     (up_stb),
        .up_busy    (up_busy),
        .dn_stb     (dn_stb),
        .dn_busy    (dn_busy),
        .out_sel    (sel),
        .spare_load (spare_load)
    );

    skid_data #(.WIDTH(WIDTH)) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_data    (up_data),
        .out_sel    (sel),
        .spare_load (spare_load),
        .dn_data    (dn_data)
    );

    // R4: a stalled output word and its strobe stay put
    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_stb && dn_busy) |=> (dn_stb && $stable(dn_data)));

endmodule

// File: rtl/skid_chain.sv
// Chain of STAGES skid stages wired strobe-to-strobe and busy-to-busy.
// Assumes: STAGES >= 1; each stage adds one clock of latency.
module skid_chain
    import skid_pkg::*;
#(
    parameter int unsigned WIDTH  = DEFAULT_WIDTH,
    parameter int unsigned STAGES = DEFAULT_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_stb,
    output logic             src_busy,
    input  logic [WIDTH-1:0] src_data,
    output logic             snk_stb,
    input  logic             snk_busy,
    output logic [WIDTH-1:0] snk_data
);

    localparam int unsigned LINKS = STAGES + 1;

    logic             stb_w  [LINKS];
    logic             busy_w [LINKS];
    logic [WIDTH-1:0] data_w [LINKS];

    assign stb_w[0]       = src_stb;
    assign data_w[0]      = src_data;
    assign src_busy       = busy_w[0];
    assign snk_stb        = stb_w[STAGES];
    assign snk_data       = data_w[STAGES];
    assign busy_w[STAGES] = snk_busy;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        skid_stage #(.WIDTH(WIDTH)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .up_stb  (stb_w[g]),
            .up_busy (busy_w[g]),
            .up_data (data_w[g]),
            .dn_stb  (stb_w[g+1]),
            .dn_busy (busy_w[g+1]),
            .dn_data (data_w[g+1])
        );
    end

    // R9: a reset edge leaves the chain empty and ready
    always_ff @(posedge clk) begin
        if (rst_n && $past(!rst_n)) begin
            p_reset_empty_r9: assert (!snk_stb && !src_busy);
        end
    end

endmodule

// File: tb/skid_chain_tb_top.sv
// Self-checking bench for the two-stage skid chain.
module skid_chain_tb_top;

    localparam int unsigned W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         src_stb = 1'b0;
    logic         src_busy;
    logic [W-1:0] src_data = '0;
    logic         snk_stb;
    logic         snk_busy = 1'b0;
    logic [W-1:0] snk_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    skid_chain #(.WIDTH(W), .STAGES(2)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_stb  (src_stb),
        .src_busy (src_busy),
        .src_data (src_data),
        .snk_stb  (snk_stb),
        .snk_busy (snk_busy),
        .snk_data (snk_data)
    );

    typedef struct packed {
        logic         stb;
        logic         busy;
        logic [W-1:0] din;
        logic         e_stb;
        logic         e_busy;
        logic [W-1:0] e_dat;
    } vec_t;

    // Inputs before an edge, expected outputs after it (data checked when e_stb)
    localparam vec_t VEC [0:10] = '{
        '{1'b1, 1'b0, 32'h0000_00A1, 1'b0, 1'b0, 32'h0},            // R8 first word in
        '{1'b1, 1'b0, 32'h0000_00B2, 1'b1, 1'b0, 32'h0000_00A1},    // R8 two edges later
        '{1'b1, 1'b0, 32'h0000_00C3, 1'b1, 1'b0, 32'h0000_00B2},
        '{1'b1, 1'b1, 32'h0000_00D4, 1'b1, 1'b0, 32'h0000_00B2},    // R3 stage 2 spare fills
        '{1'b1, 1'b1, 32'h0000_00E5, 1'b1, 1'b1, 32'h0000_00B2},    // R3 busy reaches source
        '{1'b1, 1'b1, 32'h0000_00F6, 1'b1, 1'b1, 32'h0000_00B2},    // R4 held while stalled
        '{1'b1, 1'b0, 32'h0000_00F6, 1'b1, 1'b1, 32'h0000_00C3},    // R5 spare word first
        '{1'b1, 1'b0, 32'h0000_00F6, 1'b1, 1'b0, 32'h0000_00D4},
        '{1'b1, 1'b0, 32'h0000_00F6, 1'b1, 1'b0, 32'h0000_00E5},
        '{1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_00F6},    // R7 still draining
        '{1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 32'h0}             // R7 empty, strobe drops
    };

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        src_stb  = 1'b0;
        snk_busy = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int q[$];
        bit hold;

        // R9: state after reset
        do_reset();
        chk("R9 reset snk_stb", {31'b0, snk_stb}, 32'd0);
        chk("R9 reset src_busy", {31'b0, src_busy}, 32'd0);

        // Vector table: latency, stall, spare ordering and drain
        for (int i = 0; i <= 10; i++) begin
            src_stb  = VEC[i].stb;
            snk_busy = VEC[i].busy;
            src_data = VEC[i].din;
            tick();
            chk($sformatf("R8/R3/R5/R7 row %0d snk_stb", i), {31'b0, snk_stb}, {31'b0, VEC[i].e_stb});
            chk($sformatf("R3 row %0d src_busy", i), {31'b0, src_busy}, {31'b0, VEC[i].e_busy});
            if (VEC[i].e_stb)
                chk($sformatf("R4/R5 row %0d snk_data", i), snk_data, VEC[i].e_dat);
        end

        // R6: one word per clock with no stalls
        do_reset();
        for (int i = 0; i < 20; i++) begin
            src_stb  = 1'b1;
            src_data = 32'h1000 + i;
            tick();
            if (i >= 1) begin
                chk("R6 snk_stb every clock", {31'b0, snk_stb}, 32'd1);
                chk("R6 snk_data sequence", snk_data, 32'h1000 + i - 1);
            end
        end
        src_stb = 1'b0;

        // R11: busy to source ignores mid-cycle changes of snk_busy
        do_reset();
        src_stb  = 1'b1;
        snk_busy = 1'b1;
        src_data = 32'h55;
        for (int i = 0; i < 4; i++) tick();
        chk("R11 filled busy", {31'b0, src_busy}, 32'd1);
        snk_busy = 1'b0;
        #1;
        chk("R11 busy after mid-cycle release", {31'b0, src_busy}, 32'd1);
        snk_busy = 1'b1;
        #1;

        // R9: reset in the middle of a stall empties the chain
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        src_stb = 1'b0;
        chk("R9 mid-run reset snk_stb", {31'b0, snk_stb}, 32'd0);
        chk("R9 mid-run reset src_busy", {31'b0, src_busy}, 32'd0);
        snk_busy = 1'b0;
        #1;
        chk("R11 idle busy ignores snk_busy", {31'b0, src_busy}, 32'd0);

        // R10 with R1/R2: random strobe/busy against a reference queue
        do_reset();
        hold = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (!hold) begin
                src_stb  = ($urandom % 3) != 0;
                src_data = $urandom;
            end
            snk_busy = ($urandom % 3) == 0;
            #1;
            if (src_stb && !src_busy) begin
                q.push_back(int'(src_data));  // R1 transfer taken
                hold = 1'b0;
            end else begin
                hold = src_stb;
            end
            if (snk_stb && !snk_busy) begin   // R2 transfer delivered
                if (q.size() == 0) chk("R10 unexpected word", snk_data, 32'hFFFF_FFFF);
                else chk("R10 order", snk_data, W'(q.pop_front()));
            end
            tick();
        end
        src_stb  = 1'b0;
        snk_busy = 1'b0;
        for (int i = 0; i < 6; i++) begin
            #1;
            if (snk_stb) begin
                if (q.size() == 0) chk("R10 extra word", snk_data, 32'hFFFF_FFFF);
                else chk("R10 drain order", snk_data, W'(q.pop_front()));
            end
            tick();
        end
        chk("R10 nothing lost", q.size(), 32'd0);

        finish_run();
    end

endmodule